// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block sits between a 32-bit processor load/store port and a slower word-wide main memory. It is a direct-mapped cache: each line stores a valid flag, an address tag and a four-word block. A read that finds its line valid with a matching tag returns data in the same cycle. A read that misses raises a stall. The block then fetches the whole four-word block from memory, installs it, and releases the processor.

Stores are word-sized and always go straight to memory. A store that hits also patches the one addressed word in its line. A store that misses leaves the cache untouched. A line therefore never holds words that belong to two different tags.

The processor keeps its request, address and write data steady while the stall is high. The access completes on the first cycle in which the stall is low. The memory side uses a request/acknowledge handshake with a one-cycle acknowledge pulse. Two counters record how many accesses were found as hits and how many as misses, so that the hit rate of a scripted sequence can be read out.

Top module: `dmc_cache_top`

## Requirements
- R1: A byte address splits into a byte offset (bits 1:0), a word-in-block select (bits 3:2), a line index (bits 3+IDX_W:4) and a tag made of every bit above the index, bit 31 included; any tag bit that differs gives a miss.
- R2: Reset clears every valid flag and both counters. With no request, the stall and the memory request stay low, and the first access to any line after reset is a miss.
- R3: A word read whose line is valid with an equal tag drives the stored word on cpu_rdata with cpu_stall low in the same cycle.
- R4: A read miss holds cpu_stall high from the cycle it is seen until the fourth memory acknowledge. It issues exactly four word reads at block word offsets 0, 1, 2, 3 in that order. In the cycle after the fourth acknowledge, cpu_stall is low and cpu_rdata carries the requested data.
- R5: With cpu_byte high, a read returns the byte at byte offset b (bits 8b+7:8b of the word), zero-extended to 32 bits.
- R6: Every store, hit or miss, issues exactly one memory write with the word-aligned address and the store data, and no memory read. The stall holds until that write is acknowledged.
- R7: A store hit replaces only the addressed word of its line. Later reads of that word hit and return the new value, and the other three words keep their values.
- R8: A store miss changes neither tags nor data. The line already at that index still hits, and a later read of the stored address misses and fetches the updated memory value.
- R9: hit_count rises by one for each access found as a hit in its first cycle, and miss_count by one for each miss. The completing cycle after a stall counts nothing.
- R10: Once raised, mem_req keeps mem_addr and mem_we stable until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held while stalled |
| cpu_we | input | 1 | 1 = word store, 0 = load |
| cpu_byte | input | 1 | On loads, 1 = byte load, 0 = word load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_stall is low |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory request, held until acknowledge |
| mem_we | output | 1 | 1 = memory word write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge |
| hit_count | output | CNT_W | Accesses found as hits |
| miss_count | output | CNT_W | Accesses found as misses |

## Verification
A scripted sequence first produces a cold miss and then hits on every word and byte lane of the refilled line. This separates the word-select and byte-lane paths from the tag compare. Stores are placed on a resident line and on absent lines. The follow-up reads show whether only one word was patched, and whether a store miss left the resident line alone while still reaching memory. Addresses that share an index but differ in a low tag bit or in bit 31 must evict one another, which would go unseen if the tag were cut short. A reset in the middle of the run must turn a line that was resident into a cold miss again.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

  localparam int BYTE_OFF_W = 2;
  localparam int WORD_SEL_W = 2;
  localparam int LINE_WORDS = 1 << WORD_SEL_W;
  localparam int BLK_LSB    = BYTE_OFF_W + WORD_SEL_W;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_WRITE  = 2'd2,
    ST_RESUME = 2'd3
  } dmc_state_e;

  // word-aligned address of one beat of a block refill
  function automatic logic [31:0] block_beat_addr_f(input logic [31:2] waddr,
                                                    input logic [1:0]  beat);
    return {waddr[31:4], beat, 2'b00};
  endfunction

  // word-aligned address of a single store
  function automatic logic [31:0] word_addr_f(input logic [31:2] waddr);
    return {waddr, 2'b00};
  endfunction

  // zero-extended byte lane of a word
  function automatic logic [31:0] byte_lane_f(input logic [31:0] word,
                                              input logic [1:0]  off);
    return {24'd0, word[8*off +: 8]};
  endfunction

endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (wr_en) valid_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  AST_RESET_COLD: assert property (@(posedge clk) rst |=> (valid_q == '0)); // R2
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> valid_q[$past(wr_idx)]); // R4

endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [1:0]        rd_word,
  output logic [WORD_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [1:0]        wr_word,
  input  logic [WORD_W-1:0] wr_data
);
  import dmc_pkg::*;
  localparam int LINES = 1 << IDX_W;

  logic [WORD_W-1:0] bank_rd [LINE_WORDS];

  // one storage bank per word position; a write touches one bank only
  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank_q [LINES];
    logic              bank_we;
    assign bank_we = wr_en && (wr_word == 2'(w));
    always_ff @(posedge clk) begin
      if (bank_we) bank_q[wr_idx] <= wr_data;
    end
    assign bank_rd[w] = bank_q[rd_idx];
  end

  assign rd_data = bank_rd[rd_word];

endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 24,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic [31:2]      cpu_waddr,
  input  logic [31:0]      cpu_wdata,
  input  logic             lookup_hit,
  output logic             cpu_stall,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic             tag_wr_en,
  output logic [IDX_W-1:0] line_wr_idx,
  output logic [TAG_W-1:0] line_wr_tag,
  output logic             data_wr_en,
  output logic [1:0]       data_wr_word,
  output logic [31:0]      data_wr_data,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  import dmc_pkg::*;

  dmc_state_e       state_q, state_d;
  logic [31:2]      addr_q;
  logic [31:0]      wdata_q;
  logic             hit_q;
  logic             we_q;
  logic [1:0]       beat_q;
  logic [CNT_W-1:0] hit_cnt_q, miss_cnt_q;

  // named internal events
  logic accept, acc_hit, acc_miss, go_fill, go_write;
  logic fill_beat, fill_last, write_done;

  assign accept     = (state_q == ST_IDLE) && cpu_req;
  assign acc_hit    = accept && lookup_hit;
  assign acc_miss   = accept && !lookup_hit;
  assign go_fill    = accept && !cpu_we && !lookup_hit;
  assign go_write   = accept && cpu_we;
  assign fill_beat  = (state_q == ST_FILL) && mem_ack;
  assign fill_last  = fill_beat && (beat_q == 2'd3);
  assign write_done = (state_q == ST_WRITE) && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (go_fill) state_d = ST_FILL;
                 else if (go_write) state_d = ST_WRITE;
      ST_FILL:   if (fill_last) state_d = ST_RESUME;
      ST_WRITE:  if (write_done) state_d = ST_RESUME;
      ST_RESUME: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      beat_q  <= 2'd0;
      addr_q  <= '0;
      wdata_q <= '0;
      hit_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        addr_q  <= cpu_waddr;
        wdata_q <= cpu_wdata;
        hit_q   <= lookup_hit;
        we_q    <= cpu_we;
        beat_q  <= 2'd0;
      end else if (fill_beat) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_cnt_q  <= '0;
      miss_cnt_q <= '0;
    end else begin
      if (acc_hit)  hit_cnt_q  <= hit_cnt_q + CNT_W'(1);
      if (acc_miss) miss_cnt_q <= miss_cnt_q + CNT_W'(1);
    end
  end

  assign hit_count  = hit_cnt_q;
  assign miss_count = miss_cnt_q;

  assign cpu_stall = (accept && (cpu_we || !lookup_hit))
                   || (state_q == ST_FILL) || (state_q == ST_WRITE);

  assign mem_req   = (state_q == ST_FILL) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = (state_q == ST_WRITE) ? word_addr_f(addr_q)
                                           : block_beat_addr_f(addr_q, beat_q);
  assign mem_wdata = wdata_q;

  assign tag_wr_en    = fill_last;
  assign line_wr_idx  = addr_q[4 +: IDX_W];
  assign line_wr_tag  = addr_q[31 -: TAG_W];
  assign data_wr_en   = fill_beat || (write_done && hit_q);
  assign data_wr_word = (state_q == ST_FILL) ? beat_q : addr_q[3:2];
  assign data_wr_data = (state_q == ST_FILL) ? mem_rdata : wdata_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
  AST_FILL_START: assert property (@(posedge clk) disable iff (rst)
    go_fill |=> (mem_req && !mem_we && mem_addr[3:2] == 2'd0)); // R4
  AST_FILL_ORDER: assert property (@(posedge clk) disable iff (rst)
    (fill_beat && !fill_last) |=> (mem_req && mem_addr[3:2] == 2'($past(mem_addr[3:2]) + 2'd1))); // R4
  AST_RESUME_HIT: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_RESUME) && !we_q && cpu_req && cpu_waddr == addr_q) |-> lookup_hit); // R4
  AST_WRITE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (!mem_req && !cpu_stall)); // R6
  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !accept |=> ($stable(hit_cnt_q) && $stable(miss_cnt_q))); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    accept |=> (CNT_W'(hit_cnt_q + miss_cnt_q) == CNT_W'($past(hit_cnt_q + miss_cnt_q) + CNT_W'(1)))); // R9

endmodule

// File: rtl/dmc_cache_top.sv
module dmc_cache_top #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             cpu_byte,
  input  logic [31:0]      cpu_addr,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  output logic             cpu_stall,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  input  logic             mem_ack,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  import dmc_pkg::*;
  localparam int TAG_W = 32 - IDX_W - BLK_LSB;

  logic [TAG_W-1:0] look_tag;
  logic [IDX_W-1:0] look_idx;
  logic             lookup_hit;
  logic             tag_wr_en;
  logic [IDX_W-1:0] line_wr_idx;
  logic [TAG_W-1:0] line_wr_tag;
  logic             data_wr_en;
  logic [1:0]       data_wr_word;
  logic [31:0]      data_wr_data;
  logic [31:0]      sel_word;

  assign look_tag = cpu_addr[31 -: TAG_W];
  assign look_idx = cpu_addr[BLK_LSB +: IDX_W];

  dmc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) tags_i (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (look_idx),
    .rd_tag (look_tag),
    .rd_hit (lookup_hit),
    .wr_en  (tag_wr_en),
    .wr_idx (line_wr_idx),
    .wr_tag (line_wr_tag)
  );

  dmc_data_store #(.IDX_W(IDX_W), .WORD_W(32)) data_i (
    .clk     (clk),
    .rd_idx  (look_idx),
    .rd_word (cpu_addr[3:2]),
    .rd_data (sel_word),
    .wr_en   (data_wr_en),
    .wr_idx  (line_wr_idx),
    .wr_word (data_wr_word),
    .wr_data (data_wr_data)
  );

  dmc_ctrl #(.IDX_W(IDX_W), .TAG_W(TAG_W), .CNT_W(CNT_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .cpu_req      (cpu_req),
    .cpu_we       (cpu_we),
    .cpu_waddr    (cpu_addr[31:2]),
    .cpu_wdata    (cpu_wdata),
    .lookup_hit   (lookup_hit),
    .cpu_stall    (cpu_stall),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_rdata    (mem_rdata),
    .mem_ack      (mem_ack),
    .tag_wr_en    (tag_wr_en),
    .line_wr_idx  (line_wr_idx),
    .line_wr_tag  (line_wr_tag),
    .data_wr_en   (data_wr_en),
    .data_wr_word (data_wr_word),
    .data_wr_data (data_wr_data),
    .hit_count    (hit_count),
    .miss_count   (miss_count)
  );

  assign cpu_rdata = cpu_byte ? byte_lane_f(sel_word, cpu_addr[1:0]) : sel_word;

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_byte && !cpu_we) |-> (cpu_rdata[31:8] == 24'd0)); // R5
  AST_NO_REQ_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    (!cpu_req && !mem_req) |-> !cpu_stall); // R2

endmodule

// File: tb/dmc_cache_top_tb_top.sv
`timescale 1ns/1ps
module dmc_cache_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_byte = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [15:0] hit_count, miss_count;

  always #2 clk = ~clk;

  dmc_cache_top #(.IDX_W(4), .CNT_W(16)) dut_i (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_byte(cpu_byte),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  // ---------------- memory image and responder ----------------
  logic [31:0] img [logic [29:0]];

  function automatic logic [31:0] pat_f(input logic [29:0] w);
    return {w[13:0], w[29:12]} ^ 32'h6B1D_E2F4;
  endfunction

  function automatic logic [31:0] img_rd(input logic [29:0] w);
    if (img.exists(w)) return img[w];
    return pat_f(w);
  endfunction

  int          rd_acks = 0, wr_acks = 0, seq_bad = 0, hold_bad = 0;
  logic [31:0] last_wr_addr = '0, last_wr_data = '0;
  logic [1:0]  exp_beat = 2'd0;
  logic [1:0]  dly = 2'd0;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        prev_we = 1'b0;

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      dly <= 2'd0;
      exp_beat <= 2'd0;
      prev_wait <= 1'b0;
    end else begin
      // R10: a pending request must not move
      if (prev_wait && mem_req && (mem_addr != prev_addr || mem_we != prev_we))
        hold_bad <= hold_bad + 1;
      if (prev_wait && !mem_req) hold_bad <= hold_bad + 1;
      prev_wait <= mem_req && !mem_ack;
      prev_addr <= mem_addr;
      prev_we   <= mem_we;
      if (mem_req && !mem_ack) begin
        if (dly == 2'd2) begin
          dly <= 2'd0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            img[mem_addr[31:2]] = mem_wdata;
            wr_acks <= wr_acks + 1;
            last_wr_addr <= mem_addr;
            last_wr_data <= mem_wdata;
          end else begin
            mem_rdata <= img_rd(mem_addr[31:2]);
            rd_acks <= rd_acks + 1;
            if (mem_addr[3:2] != exp_beat || mem_addr[1:0] != 2'b00) seq_bad <= seq_bad + 1;
            exp_beat <= exp_beat + 2'd1;
          end
        end else begin
          dly <= dly + 2'd1;
        end
      end
    end
  end

  // ---------------- check bookkeeping ----------------
  int total = 0, bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // {we, byte, addr[31:0], wdata[31:0], exp_hit}; index = addr[7:4], tag = addr[31:8]
  localparam int NV = 17;
  localparam logic [66:0] VECS [NV] = '{
    {1'b0, 1'b0, 32'h0000_1120, 32'h0000_0000, 1'b0},  // R2 cold miss, R4
    {1'b0, 1'b1, 32'h0000_1125, 32'h0000_0000, 1'b1},  // R5 byte 1 of word 1
    {1'b0, 1'b0, 32'h0000_112C, 32'h0000_0000, 1'b1},  // R3 word 3
    {1'b1, 1'b0, 32'h0000_1128, 32'hDEAD_BEEF, 1'b1},  // R6 R7 store hit
    {1'b0, 1'b0, 32'h0000_1128, 32'h0000_0000, 1'b1},  // R7 new value
    {1'b0, 1'b0, 32'h0000_1124, 32'h0000_0000, 1'b1},  // R7 neighbour kept
    {1'b1, 1'b0, 32'h0000_2230, 32'h1234_5678, 1'b0},  // R8 store miss
    {1'b0, 1'b0, 32'h0000_2230, 32'h0000_0000, 1'b0},  // R8 no allocate
    {1'b0, 1'b0, 32'h0000_3320, 32'h0000_0000, 1'b0},  // R1 conflict
    {1'b0, 1'b0, 32'h0000_1120, 32'h0000_0000, 1'b0},  // R1 evicted
    {1'b0, 1'b1, 32'h0000_1123, 32'h0000_0000, 1'b1},  // R5 byte 3
    {1'b0, 1'b1, 32'h0000_112A, 32'h0000_0000, 1'b1},  // R5 byte 2, R6 written through
    {1'b1, 1'b0, 32'h0000_4420, 32'hCAFE_F00D, 1'b0},  // R8 store miss, same index
    {1'b0, 1'b0, 32'h0000_1120, 32'h0000_0000, 1'b1},  // R8 resident line kept
    {1'b0, 1'b0, 32'h8000_1120, 32'h0000_0000, 1'b0},  // R1 top tag bit
    {1'b0, 1'b0, 32'h0000_4420, 32'h0000_0000, 1'b0},  // R8 fetch stored value
    {1'b0, 1'b1, 32'h0000_4424, 32'h0000_0000, 1'b1}   // R5 byte 0
  };

  task automatic access(input logic [66:0] v);
    logic        st0;
    logic [31:0] got, word, expv;
    int          rd0, wr0, waitc;
    logic [15:0] h0, m0;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = v[66]; cpu_byte = v[65];
    cpu_addr = v[64:33]; cpu_wdata = v[32:1];
    rd0 = rd_acks; wr0 = wr_acks; h0 = hit_count; m0 = miss_count;
    #0.5;
    st0 = cpu_stall;
    waitc = 0;
    while (cpu_stall && waitc < 100) begin
      @(negedge clk); #0.5; waitc++;
    end
    got = cpu_rdata;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    chk(waitc < 100, "R4 access completes", 32'(waitc), 32'd100);
    if (!v[66]) begin
      word = img_rd(v[64:35]);
      expv = v[65] ? ((word >> (8 * v[34:33])) & 32'hFF) : word;
      if (v[0]) chk(st0 == 1'b0, "R3 hit returns without stall", 32'(st0), 32'd0);
      else begin
        chk(st0 == 1'b1, "R4 miss stalls", 32'(st0), 32'd1);
        chk(rd_acks - rd0 == 4, "R4 four refill reads", 32'(rd_acks - rd0), 32'd4);
      end
      chk(got == expv, v[65] ? "R5 byte load data" : "R3 R4 load data", got, expv);
    end else begin
      chk(st0 == 1'b1, "R6 store stalls", 32'(st0), 32'd1);
      chk(wr_acks - wr0 == 1 && rd_acks == rd0, "R6 one write no read", 32'(wr_acks - wr0), 32'd1);
      chk(last_wr_addr == {v[64:35], 2'b00}, "R6 write address", last_wr_addr, {v[64:35], 2'b00});
      chk(last_wr_data == v[32:1], "R6 write data", last_wr_data, v[32:1]);
    end
    chk(hit_count - h0 == 16'(v[0]), "R9 hit counter step", 32'(hit_count - h0), 32'(v[0]));
    chk(miss_count - m0 == 16'(!v[0]), "R9 miss counter step", 32'(miss_count - m0), 32'(!v[0]));
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h_all, m_all;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0.5;
    // R2 reset state
    chk(cpu_stall == 1'b0, "R2 stall low after reset", 32'(cpu_stall), 32'd0);
    chk(mem_req == 1'b0, "R2 no memory request after reset", 32'(mem_req), 32'd0);
    chk(hit_count == 0 && miss_count == 0, "R2 counters cleared", {hit_count, miss_count}, 32'd0);
    repeat (5) @(negedge clk);
    chk(rd_acks == 0 && wr_acks == 0, "R2 idle makes no traffic", 32'(rd_acks + wr_acks), 32'd0);

    for (int i = 0; i < NV; i++) access(VECS[i]);

    h_all = 0; m_all = 0;
    for (int i = 0; i < NV; i++) begin
      if (VECS[i][0]) h_all++; else m_all++;
    end
    chk(hit_count == 16'(h_all), "R9 total hits", 32'(hit_count), 32'(h_all));
    chk(miss_count == 16'(m_all), "R9 total misses", 32'(miss_count), 32'(m_all));
    chk(seq_bad == 0, "R4 refill order 0..3", 32'(seq_bad), 32'd0);
    chk(hold_bad == 0, "R10 request held until ack", 32'(hold_bad), 32'd0);

    // R2 reset in mid-run clears lines and counters
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    #0.5;
    chk(hit_count == 0 && miss_count == 0, "R2 counters cleared again", {hit_count, miss_count}, 32'd0);
    access({1'b0, 1'b1, 32'h0000_4424, 32'h0, 1'b0});   // R2 resident line now cold
    access({1'b0, 1'b0, 32'h0000_4428, 32'h0, 1'b1});   // R3 hit after refill

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule